// File: doc/BRIEF.md
# Condition-Field Masked LUT Unit

This unit holds a 32-bit condition register made of eight 4-bit condition fields. On each accepted instruction it rewrites up to four bits of one destination field. Every destination bit is computed on its own from the bits in the same position of the source fields, using a truth table. The truth table is either an 8-bit ternary table taken from the instruction word, or a 4-bit binary table read at run time from a third condition field.

A 4-bit write mask in the instruction chooses which bits of the destination field are written. The other bits keep their old values. The instruction word and a one-cycle valid strobe are the only inputs. The updated register is visible on the output one clock edge after the strobe.

Instruction bit positions use big-endian numbering, so instruction bit k is `insn_i[31-k]`. Field n occupies `cr_o[31-4n : 28-4n]`. Within a field, field bit 0 is the most significant bit.

Top module: `cr_lut_unit`

## Requirements
- R1: While `rst_ni` is low the register reads `CR_RESET`, which is 0 by default. The reset is asynchronous.
- R2: Ternary form (primary opcode in bits 0:5 = `OPC_PRI`, default 22; extended opcode in bits 26:30 = `XO_TERN`, default 4). The table is T = {bits 19..25, bit 31}, with bit 19 as T[7]. Each written bit becomes T[{old destination bit, A bit, B bit}].
- R3: Binary form (extended opcode = `XO_BIN`, default 12). Bits 19:21 select a table field C. Each written bit becomes C[{A bit, B bit}], where field bit 0 of C is index 3 and field bit 3 is index 0.
- R4: The destination field is selected by bits 6:8, source A by bits 11:13 and source B by bits 16:18. Field 0 is the top nibble of the register.
- R5: The write mask is {bits 9,10,14,15}. Its MSB enables field bit 0. Destination bits whose mask bit is 0 keep their value, and a mask of 0 changes nothing.
- R6: The register changes on the clock edge that samples `valid_i` high. Only the destination field may change. Back-to-back strobes each see the result of the one before.
- R7: With `valid_i` low the register holds, whatever `insn_i` carries.
- R8: A strobe whose primary opcode is not `OPC_PRI`, or whose extended opcode matches neither form, leaves the register unchanged.
- R9: All sources are read from the register value before the update. This holds even when a source field is the destination field.
- R10: In the binary form, bits 22:25 and bit 31 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | One-cycle strobe accepting `insn_i` |
| insn_i | input | 32 | Instruction word |
| cr_o | output | 32 | Condition register contents |

## Verification
Four properties are checked on every cycle:
- The register holds whenever no strobe is present.
- The register holds when a strobe carries an unrecognized opcode.
- A strobe changes no bit outside the destination field.
- A strobe changes no destination bit whose mask bit is clear.

For the ternary form, an all-ones or all-zeros table must set or clear exactly the masked bits. That result does not depend on the operands, so it is also checked on every cycle.

The remaining behaviours can only be shown by the bench's scenarios, which compare the register against hand-computed values:
- the actual table lookups with real operand bits;
- the index ordering of {old, A, B} and {A, B};
- field numbering and read-before-write when a source is the destination;
- the ignored reserved bits of the binary form.

// File: rtl/cr_lut_pkg.sv
package cr_lut_pkg;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = 8;
  localparam int SEL_W      = $clog2(NUM_FIELDS);
  localparam int CR_W       = FIELD_W * NUM_FIELDS;
  localparam int TERN_IN    = 3;
  localparam int TBL_W      = 2 ** TERN_IN;
  localparam int BIN_IN     = 2;
  localparam int LUT_W      = 2 ** BIN_IN;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_TERN = 2'd1,
    OP_BIN  = 2'd2
  } op_e;

  typedef struct packed {
    op_e                op;
    logic [SEL_W-1:0]   bf;
    logic [SEL_W-1:0]   bfa;
    logic [SEL_W-1:0]   bfb;
    logic [SEL_W-1:0]   bfc;
    logic [FIELD_W-1:0] mask;
    logic [TBL_W-1:0]   tbl;
  } dec_t;
endpackage

// File: rtl/cr_lut_decode.sv
module cr_lut_decode
  import cr_lut_pkg::*;
#(
  parameter logic [5:0] OPC_PRI = 6'd22,
  parameter logic [4:0] XO_TERN = 5'd4,
  parameter logic [4:0] XO_BIN  = 5'd12
) (
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  // big-endian bit k lives at insn_i[31-k]
  logic [5:0] po;
  logic [4:0] xo;

  assign po = insn_i[31:26];
  assign xo = insn_i[5:1];

  always_comb begin
    dec_o.bf   = insn_i[25:23];
    dec_o.bfa  = insn_i[20:18];
    dec_o.bfb  = insn_i[15:13];
    dec_o.bfc  = insn_i[12:10];
    dec_o.mask = {insn_i[22:21], insn_i[17:16]};
    dec_o.tbl  = {insn_i[12:6], insn_i[0]};
    dec_o.op   = OP_NONE;
    if (valid_i && po == OPC_PRI) begin
      if (xo == XO_TERN)     dec_o.op = OP_TERN;
      else if (xo == XO_BIN) dec_o.op = OP_BIN;
    end
  end
endmodule

// File: rtl/cr_lut_field_sel.sv
module cr_lut_field_sel #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int SEL_W     = $clog2(NUM_FIELDS),
  localparam int CR_W      = NUM_FIELDS * FIELD_W
) (
  input  logic [CR_W-1:0]    cr_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [FIELD_W-1:0] field_o
);
  logic [FIELD_W-1:0] flds [NUM_FIELDS];

  // field 0 is the top nibble
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign flds[g] = cr_i[CR_W-1-g*FIELD_W -: FIELD_W];
  end

  assign field_o = flds[sel_i];
endmodule

// File: rtl/cr_lut_bit_eval.sv
module cr_lut_bit_eval
  import cr_lut_pkg::*;
#(
  parameter int W = 4
) (
  input  op_e              op_i,
  input  logic [TBL_W-1:0] tbl_i,
  input  logic [LUT_W-1:0] lut_i,
  input  logic [W-1:0]     d_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [W-1:0]     res_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [TERN_IN-1:0] t_idx;
    logic [BIN_IN-1:0]  b_idx;
    logic               t_bit;
    logic               b_bit;

    assign t_idx    = {d_i[g], a_i[g], b_i[g]};
    assign b_idx    = {a_i[g], b_i[g]};
    assign t_bit    = tbl_i[t_idx];
    assign b_bit    = lut_i[b_idx];
    assign res_o[g] = (op_i == OP_BIN) ? b_bit : t_bit;
  end
endmodule

// File: rtl/cr_lut_unit.sv
module cr_lut_unit
  import cr_lut_pkg::*;
#(
  parameter logic [5:0]      OPC_PRI  = 6'd22,
  parameter logic [4:0]      XO_TERN  = 5'd4,
  parameter logic [4:0]      XO_BIN   = 5'd12,
  parameter logic [CR_W-1:0] CR_RESET = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  output logic [CR_W-1:0] cr_o
);
  dec_t               dec;
  logic [CR_W-1:0]    cr_q;
  logic [CR_W-1:0]    cr_nxt;
  logic [FIELD_W-1:0] fld_d;
  logic [FIELD_W-1:0] fld_a;
  logic [FIELD_W-1:0] fld_b;
  logic [FIELD_W-1:0] fld_c;
  logic [FIELD_W-1:0] res;
  logic               wr_en;

  cr_lut_decode #(
    .OPC_PRI (OPC_PRI),
    .XO_TERN (XO_TERN),
    .XO_BIN  (XO_BIN)
  ) u_dec (
    .valid_i (valid_i),
    .insn_i  (insn_i),
    .dec_o   (dec)
  );

  // all reads come from cr_q: read-before-write
  cr_lut_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_d (
    .cr_i(cr_q), .sel_i(dec.bf),  .field_o(fld_d)
  );
  cr_lut_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_a (
    .cr_i(cr_q), .sel_i(dec.bfa), .field_o(fld_a)
  );
  cr_lut_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_b (
    .cr_i(cr_q), .sel_i(dec.bfb), .field_o(fld_b)
  );
  cr_lut_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_c (
    .cr_i(cr_q), .sel_i(dec.bfc), .field_o(fld_c)
  );

  cr_lut_bit_eval #(.W(FIELD_W)) u_eval (
    .op_i  (dec.op),
    .tbl_i (dec.tbl),
    .lut_i (fld_c),
    .d_i   (fld_d),
    .a_i   (fld_a),
    .b_i   (fld_b),
    .res_o (res)
  );

  assign wr_en = (dec.op != OP_NONE);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_merge
    logic               hit;
    logic [FIELD_W-1:0] old_f;

    assign hit   = wr_en && (dec.bf == SEL_W'(g));
    assign old_f = cr_q[CR_W-1-g*FIELD_W -: FIELD_W];
    assign cr_nxt[CR_W-1-g*FIELD_W -: FIELD_W] =
      hit ? ((old_f & ~dec.mask) | (res & dec.mask)) : old_f;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cr_q <= CR_RESET;
    else if (wr_en) cr_q <= cr_nxt;
  end

  assign cr_o = cr_q;
endmodule

// File: rtl/cr_lut_chk.sv
module cr_lut_chk
  import cr_lut_pkg::*;
#(
  parameter logic [5:0] OPC_PRI = 6'd22,
  parameter logic [4:0] XO_TERN = 5'd4,
  parameter logic [4:0] XO_BIN  = 5'd12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [5:0]         po_i,
  input logic [SEL_W-1:0]   bf_i,
  input logic [FIELD_W-1:0] mask_i,
  input logic [TBL_W-1:0]   tbl_i,
  input logic [4:0]         xo_i,
  input logic [CR_W-1:0]    cr_o
);
  logic            legal;
  logic            is_tern;
  logic [CR_W-1:0] fld_mask;
  logic [CR_W-1:0] bit_mask;
  int              sh;

  assign legal    = (po_i == OPC_PRI) && (xo_i == XO_TERN || xo_i == XO_BIN);
  assign is_tern  = (po_i == OPC_PRI) && (xo_i == XO_TERN);
  assign sh       = FIELD_W * (NUM_FIELDS - 1 - int'(bf_i));
  assign fld_mask = CR_W'({FIELD_W{1'b1}}) << sh;
  assign bit_mask = CR_W'(mask_i) << sh;

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cr_o));

  // R8
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !legal) |=> $stable(cr_o));

  // R6
  other_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((cr_o ^ $past(cr_o)) & ~$past(fld_mask)) == '0);

  // R5
  masked_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((cr_o ^ $past(cr_o)) & ~$past(bit_mask)) == '0);

  // R2
  tern_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_tern && tbl_i == '1) |=> (cr_o & $past(bit_mask)) == $past(bit_mask));

  // R2
  tern_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_tern && tbl_i == '0) |=> (cr_o & $past(bit_mask)) == '0);
endmodule

bind cr_lut_unit cr_lut_chk #(
  .OPC_PRI (OPC_PRI),
  .XO_TERN (XO_TERN),
  .XO_BIN  (XO_BIN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .po_i    (insn_i[31:26]),
  .bf_i    (insn_i[25:23]),
  .mask_i  ({insn_i[22:21], insn_i[17:16]}),
  .tbl_i   ({insn_i[12:6], insn_i[0]}),
  .xo_i    (insn_i[5:1]),
  .cr_o    (cr_o)
);

// File: tb/sim_cr_lut_unit.sv
module sim_cr_lut_unit;
  localparam logic [5:0] PO  = 6'd22;
  localparam logic [4:0] XT  = 5'd4;
  localparam logic [4:0] XB  = 5'd12;
  localparam int         NV  = 13;

  // {kind, bf, mask, bfa, bfb, table/lut-sel, expected}
  // kind: 0 ternary, 1 binary, 2 bad extended opcode, 3 bad primary opcode
  localparam logic [54:0] VEC [NV] = '{
    {2'd0, 3'd0, 4'hF, 3'd1, 3'd0, 8'hFF, 32'hF000_0000}, // R4 field 0 = top nibble
    {2'd0, 3'd2, 4'hF, 3'd1, 3'd0, 8'hAA, 32'hF0F0_0000}, // result = B
    {2'd0, 3'd3, 4'hA, 3'd0, 3'd0, 8'hFF, 32'hF0FA_0000}, // partial mask
    {2'd0, 3'd4, 4'hF, 3'd3, 3'd0, 8'hCC, 32'hF0FA_A000}, // result = A
    {2'd1, 3'd5, 4'hF, 3'd3, 3'd2, 8'h03, 32'hF0FA_AF00}, // lut from field 3
    {2'd0, 3'd3, 4'hF, 3'd0, 3'd0, 8'h0F, 32'hF0F5_AF00}, // ~old dest
    {2'd0, 3'd0, 4'h0, 3'd0, 3'd0, 8'h00, 32'hF0F5_AF00}, // mask 0
    {2'd0, 3'd7, 4'h1, 3'd0, 3'd0, 8'hFF, 32'hF0F5_AF01}, // mask LSB = field bit 3
    {2'd1, 3'd6, 4'hC, 3'd7, 3'd3, 8'h05, 32'hF0F5_AFC1},
    {2'd1, 3'd1, 4'hF, 3'd3, 3'd6, 8'hFB, 32'hF3F5_AFC1}, // R10 reserved bits set
    {2'd2, 3'd0, 4'hF, 3'd0, 3'd0, 8'h00, 32'hF3F5_AFC1},
    {2'd3, 3'd0, 4'hF, 3'd0, 3'd0, 8'h00, 32'hF3F5_AFC1},
    {2'd0, 3'd4, 4'hF, 3'd6, 3'd3, 8'hCA, 32'hF3F5_DFC1}  // mux: old ? A : B
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] cr_o;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #2 clk_i = ~clk_i;

  cr_lut_unit u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .insn_i  (insn_i),
    .cr_o    (cr_o)
  );

  function automatic logic [31:0] mk(input logic [1:0] kind, input logic [2:0] bf,
                                     input logic [3:0] m, input logic [2:0] a,
                                     input logic [2:0] b, input logic [7:0] t);
    logic [31:0] w;
    w = '0;
    w[31:26] = (kind == 2'd3) ? (PO ^ 6'd1) : PO;
    w[25:23] = bf;
    w[22:21] = m[3:2];
    w[20:18] = a;
    w[17:16] = m[1:0];
    w[15:13] = b;
    if (kind == 2'd1) begin
      w[12:10] = t[2:0];
      w[9:6]   = t[6:3];
      w[0]     = t[7];
      w[5:1]   = XB;
    end else begin
      w[12:6] = t[7:1];
      w[0]    = t[0];
      w[5:1]  = (kind == 2'd2) ? 5'd31 : XT;
    end
    return w;
  endfunction

  task automatic chk(input logic [31:0] exp, input string req);
    n_chk++;
    if (cr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: cr_o=%h expected %h", req, cr_o, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk_i);
    valid_i = 1'b1;
    insn_i  = w;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string req;
    #5;
    chk(32'h0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(32'h0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VEC[i];
      issue(mk(v[54:53], v[52:50], v[49:46], v[45:43], v[42:40], v[39:32]));
      case (v[54:53])
        2'd0:    req = "R2";
        2'd1:    req = "R3";
        default: req = "R8";
      endcase
      if (i == 0) req = "R4";
      if (v[49:46] != 4'hF) req = "R5";
      if (v[54:53] == 2'd1 && v[39]) req = "R10";
      chk(v[31:0], req);
    end

    // R7: strobe low, set-all instruction on the bus
    @(negedge clk_i);
    insn_i = mk(2'd0, 3'd1, 4'hF, 3'd0, 3'd0, 8'hFF);
    repeat (3) @(negedge clk_i);
    chk(32'hF3F5_DFC1, "R7");

    // R9: source A is the destination, result = ~A
    issue(mk(2'd0, 3'd2, 4'hF, 3'd2, 3'd0, 8'h33));
    chk(32'hF305_DFC1, "R9");

    // R6: back-to-back inversions of field 7
    @(negedge clk_i);
    valid_i = 1'b1;
    insn_i  = mk(2'd0, 3'd7, 4'hF, 3'd0, 3'd0, 8'h0F);
    @(negedge clk_i);
    chk(32'hF305_DFCE, "R6");
    insn_i  = mk(2'd0, 3'd7, 4'hF, 3'd0, 3'd0, 8'h0F);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(32'hF305_DFC1, "R6");

    // R1: asynchronous reset mid-run
    #1;
    rst_ni = 1'b0;
    #1;
    chk(32'h0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule